// File: doc/BRIEF.md
# Dual-Source Selectable Tick Prescaler

This block turns two oscillator domains into per-channel count-enable ticks for a bank of down-counters. It runs entirely on the system clock. Each oscillator arrives as a one-cycle enable strobe: a slow strobe at 32.768 kHz and a fast strobe at 4 MHz. Each source feeds one free-running binary divider: 7 bits for the slow source and 12 bits for the fast one. Every channel picks a source and a 3-bit rate code, and takes its tick from the rollover of the matching divider tap.

Channels come in pairs. Each pair shares one 8-bit configuration byte that holds two rate codes and two channel enables. A separate per-channel select input chooses the source. The fast oscillator can be gated off on its own. A sleep input freezes both dividers and silences every channel, and the dividers resume from where they stopped when sleep is released.

Top module: `dual_src_prescaler`

## Requirements
- R1: With select bit 1 (slow source), rate codes 0..7 give one tick per 1, 2, 4, 8, 16, 32, 64, 128 slow strobes respectively.
- R2: With select bit 0 (fast source), rate codes 0..7 give one tick per 2, 8, 32, 64, 128, 256, 1024, 4096 fast strobes respectively.
- R3: In each pair's configuration byte, bits 2:0 hold the even channel's rate code and bit 3 its enable, while bits 6:4 hold the odd channel's rate code and bit 7 its enable. A write applies only to the pair whose write strobe is high. All bytes reset to 0.
- R4: A channel whose enable bit is 0 never raises its tick.
- R5: While the fast-oscillator enable is low, no channel on the fast source ticks and the fast divider holds, but slow-source channels keep ticking.
- R6: While sleep is high, no channel ticks and both dividers hold. After wake-up, counting resumes from the held divider value.
- R7: A tick is one system-clock cycle wide. It is high in the cycle that follows the clock edge which samples the qualifying strobe. Strobes never arrive on consecutive cycles.
- R8: Both dividers clear on reset, so the first tick of a channel lands on the N-th strobe after reset, where N is its division ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_stb | input | 1 | Slow (32.768 kHz) oscillator strobe, one cycle wide |
| hi_stb | input | 1 | Fast (4 MHz) oscillator strobe, one cycle wide |
| hi_osc_en | input | 1 | Fast oscillator enable |
| sleep | input | 1 | Stops both dividers and all ticks |
| cfg_we | input | NPAIR | Per-pair configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| src_sel | input | 2*NPAIR | Per-channel source select, 1 = slow, 0 = fast |
| tick | output | 2*NPAIR | Per-channel count-enable pulse |

## Verification
Each tick has a single register between the strobe and the output, so it is due in the cycle right after the rising edge that captures the strobe. The bench drives stimulus just after a rising edge and samples on the falling edge that follows the capture edge. It counts every tick over a run of a whole number of division periods, so each rate check has an exact expected count. It also checks the one-cycle width and the exact landing cycle of the first tick directly. Configuration writes take effect one edge after the write, and the bench always finishes a write before it sends the first strobe.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int CODE_W = 3;
  localparam int LO_W   = 7;
  localparam int HI_W   = 12;

  // Fast source: tap depth (log2 of division ratio) for each rate code
  function automatic logic [3:0] hi_tap(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    hi_tap = 4'd1;
      3'd1:    hi_tap = 4'd3;
      3'd2:    hi_tap = 4'd5;
      3'd3:    hi_tap = 4'd6;
      3'd4:    hi_tap = 4'd7;
      3'd5:    hi_tap = 4'd8;
      3'd6:    hi_tap = 4'd10;
      default: hi_tap = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/presc_chain.sv
module presc_chain #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic         run,
  output logic [W:0]   lvl
);
  logic [W-1:0] cnt;
  logic         fire;

  assign fire = stb & run;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (fire) cnt <= cnt + 1'b1;
  end

  // lvl[k] marks a rollover of the divide-by-2^k tap on this strobe
  assign lvl[0] = fire;
  for (genvar k = 1; k <= W; k++) begin : g_lvl
    assign lvl[k] = fire & (&cnt[k-1:0]);
  end

  // R6: divider holds while stopped
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
endmodule

// File: rtl/presc_tap.sv
module presc_tap
  import presc_pkg::*;
#(
  parameter int LW = LO_W,
  parameter int HW = HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW:0]       lo_lvl,
  input  logic [HW:0]       hi_lvl,
  input  logic              sel,
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic              tick
);
  logic [3:0] hi_idx;
  logic       hit;

  assign hi_idx = hi_tap(code);
  assign hit    = sel ? lo_lvl[code] : hi_lvl[hi_idx];

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= en & hit;
  end

  // R4: disabled channel stays quiet
  a_r4_en_gate: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
endmodule

// File: rtl/dual_src_prescaler.sv
module dual_src_prescaler
  import presc_pkg::*;
#(
  parameter int NPAIR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lo_stb,
  input  logic               hi_stb,
  input  logic               hi_osc_en,
  input  logic               sleep,
  input  logic [NPAIR-1:0]   cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic [2*NPAIR-1:0] src_sel,
  output logic [2*NPAIR-1:0] tick
);
  localparam int NCH = 2 * NPAIR;

  logic [7:0]    cfg_q [NPAIR];
  logic [LO_W:0] lo_lvl;
  logic [HI_W:0] hi_lvl;
  logic          lo_run, hi_run;

  assign lo_run = ~sleep;
  assign hi_run = hi_osc_en & ~sleep;

  for (genvar p = 0; p < NPAIR; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)            cfg_q[p] <= 8'h00;
      else if (cfg_we[p]) cfg_q[p] <= cfg_wdata;
    end
  end

  presc_chain #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .stb(lo_stb), .run(lo_run), .lvl(lo_lvl)
  );

  presc_chain #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .stb(hi_stb), .run(hi_run), .lvl(hi_lvl)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P = c / 2;
    localparam int B = (c % 2) * 4;
    presc_tap #(.LW(LO_W), .HW(HI_W)) u_tap (
      .clk(clk), .rst(rst),
      .lo_lvl(lo_lvl), .hi_lvl(hi_lvl),
      .sel(src_sel[c]),
      .code(cfg_q[P][B +: CODE_W]),
      .en(cfg_q[P][B+3]),
      .tick(tick[c])
    );

    // R7: ticks are single-cycle pulses
    a_r7_single: assert property (@(posedge clk) disable iff (rst)
      tick[c] |=> !tick[c]);
  end

  // R7: strobes arrive with at least one idle cycle between them
  a_r7_lo_gap: assert property (@(posedge clk) disable iff (rst)
    lo_stb |=> !lo_stb);
  a_r7_hi_gap: assert property (@(posedge clk) disable iff (rst)
    hi_stb |=> !hi_stb);

  // R6: sleep silences every channel
  a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (tick == '0));

  // R5: fast source off silences fast-source channels
  a_r5_hi_off: assert property (@(posedge clk) disable iff (rst)
    !hi_osc_en |=> ((tick & ~$past(src_sel)) == '0));
endmodule

// File: tb/tb_dual_src_prescaler.sv
module tb_dual_src_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 2;
  localparam int NCH = 2 * NPAIR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_stb = 1'b0, hi_stb = 1'b0, hi_osc_en = 1'b1, sleep = 1'b0;
  logic [NPAIR-1:0] cfg_we = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NCH-1:0] src_sel = '0;
  logic [NCH-1:0] tick;

  int n_tests = 0, n_fail = 0;
  int tcnt [NCH];
  int width_err = 0;
  logic [NCH-1:0] prev_tick = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_src_prescaler #(.NPAIR(NPAIR)) dut (
    .clk(clk), .rst(rst), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .hi_osc_en(hi_osc_en), .sleep(sleep), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .src_sel(src_sel), .tick(tick)
  );

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (tick[c]) begin
        tcnt[c] = tcnt[c] + 1;
        if (prev_tick[c]) width_err = width_err + 1;
      end
    end
    prev_tick = tick;
  end

  typedef struct packed {
    int        req;
    logic [7:0] cfg;
    logic [1:0] src;
    logic       hien;
    logic       slp;
    int        nlo;
    int        nhi;
    int        e0;
    int        e1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1, 8'h88, 2'b11, 1'b1, 1'b0, 8,    0,    8,   8},  // R1 div1
    '{1, 8'hA9, 2'b11, 1'b1, 1'b0, 8,    0,    4,   2},  // R1 div2/div4
    '{1, 8'hCB, 2'b11, 1'b1, 1'b0, 32,   0,    4,   2},  // R1 div8/div16
    '{1, 8'hED, 2'b11, 1'b1, 1'b0, 128,  0,    4,   2},  // R1 div32/div64
    '{2, 8'hF8, 2'b10, 1'b1, 1'b0, 256,  16,   8,   2},  // R2 div2 + R1 div128
    '{2, 8'hBA, 2'b00, 1'b1, 1'b0, 0,    128,  4,   2},  // R2 div32/div64
    '{2, 8'hE9, 2'b00, 1'b1, 1'b0, 0,    2048, 256, 2},  // R2 div8/div1024
    '{2, 8'hDF, 2'b00, 1'b1, 1'b0, 0,    4096, 1,   16}, // R2 div4096/div256
    '{4, 8'h77, 2'b11, 1'b1, 1'b0, 16,   16,   0,   0},  // R4 enables clear
    '{3, 8'h80, 2'b11, 1'b1, 1'b0, 4,    0,    0,   4},  // R3 odd channel only
    '{5, 8'h88, 2'b00, 1'b0, 1'b0, 16,   16,   0,   0},  // R5 fast off
    '{5, 8'h88, 2'b10, 1'b0, 1'b0, 16,   16,   0,   16}, // R5 slow keeps going
    '{6, 8'h88, 2'b10, 1'b1, 1'b1, 16,   16,   0,   0}   // R6 sleep
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int c = 0; c < NCH; c++) tcnt[c] = 0;
    width_err = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; cfg_we = '0; lo_stb = 0; hi_stb = 0;
    @(posedge clk); #1;
    rst = 1'b0;
    clear_counts();
  endtask

  task automatic write_cfg(input int pair, input logic [7:0] v);
    @(posedge clk); #1;
    cfg_we = '0; cfg_we[pair] = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = '0;
  endtask

  task automatic step(input logic l, input logic h);
    @(posedge clk); #1;
    lo_stb = l; hi_stb = h;
    @(posedge clk); #1;
    lo_stb = 0; hi_stb = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R3/R8 reset state: quiet output, configuration cleared
    do_reset();
    @(negedge clk);
    chk("R3 reset tick", int'(tick), 0);
    src_sel = '1;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
    settle();
    chk("R3 reset cfg zero ch0", tcnt[0], 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg(0, VEC[v].cfg);
      src_sel = {2'b00, VEC[v].src};
      hi_osc_en = VEC[v].hien;
      sleep = VEC[v].slp;
      for (int i = 0; i < 4096; i++) begin
        if (i >= VEC[v].nlo && i >= VEC[v].nhi) break;
        step(i < VEC[v].nlo, i < VEC[v].nhi);
      end
      settle();
      chk($sformatf("R%0d vec%0d ch0", VEC[v].req, v), tcnt[0], VEC[v].e0);
      chk($sformatf("R%0d vec%0d ch1", VEC[v].req, v), tcnt[1], VEC[v].e1);
      chk($sformatf("R7 vec%0d width", v), width_err, 0);
      chk($sformatf("R3 vec%0d pair1 idle", v), tcnt[2] + tcnt[3], 0);
      hi_osc_en = 1'b1; sleep = 1'b0;
    end

    // R7/R8 exact landing cycle of the first tick
    do_reset();
    src_sel = 4'b0001;
    write_cfg(0, 8'h88);
    @(posedge clk); #1; lo_stb = 1'b1;
    @(posedge clk); #1; lo_stb = 1'b0;
    @(negedge clk);
    chk("R7 tick due cycle", int'(tick[0]), 1);
    @(negedge clk);
    chk("R7 tick drops", int'(tick[0]), 0);

    // R8 first tick on the N-th strobe (fast div8)
    do_reset();
    src_sel = '0;
    write_cfg(0, 8'h09);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
    settle();
    chk("R8 before 8th strobe", tcnt[0], 0);
    step(1'b0, 1'b1);
    settle();
    chk("R8 on 8th strobe", tcnt[0], 1);

    // R6 hold and resume across sleep (slow div8)
    do_reset();
    src_sel = 4'b0001;
    write_cfg(0, 8'h0B);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    sleep = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    settle();
    chk("R6 silent in sleep", tcnt[0], 0);
    sleep = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    settle();
    chk("R6 resume no early tick", tcnt[0], 0);
    step(1'b1, 1'b0);
    settle();
    chk("R6 resume tick", tcnt[0], 1);

    // R5 fast divider holds while gated (fast div8)
    do_reset();
    src_sel = '0;
    write_cfg(0, 8'h09);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    hi_osc_en = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    hi_osc_en = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    settle();
    chk("R5 fast hold resume", tcnt[0], 1);

    // R3 write to pair 1 only affects pair 1
    do_reset();
    src_sel = '1;
    write_cfg(1, 8'h88);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    settle();
    chk("R3 pair1 ch2", tcnt[2], 4);
    chk("R3 pair1 ch3", tcnt[3], 4);
    chk("R3 pair0 untouched", tcnt[0] + tcnt[1], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule